// File: doc/BRIEF.md
# Pipelined Register Write Scheduler

This block stands between a host that writes configuration registers and a deep fixed-function rendering pipeline. Every register address belongs to one category, and the category decides when the write takes effect. Ordinary pipeline state is queued, so it reaches the pipeline in step with the primitives written before and after it. Mode registers are queued as well, but they are released only when the pipeline reports that it has no work left in flight. A few control registers bypass the queue and take effect at once. Every fixed-point register also has a floating-point twin 128 addresses higher. A value written there is converted from IEEE single precision into that register's fixed-point format and is queued under the base address.

A write to the primitive command register, at either its fixed or its float address, reaches the pipeline through the queue and is flagged as a start-primitive command. This means all state written before it is already applied when the primitive starts. Writes to addresses outside the map are accepted and dropped.

Top module: `regsched_top`

## Requirements
- R1: Writes to the queued registers 0x08 (red start), 0x09 (green start), 0x0C (x position) and 0x10 (primitive command) come out on the apply port in arrival order. If the queue is empty, a write accepted at a clock edge appears on `apply_valid` in the cycle after that edge. One entry leaves per cycle in which `apply_valid` and `pipe_accept` are both high.
- R2: Writes to the drain-stall registers 0x20 and 0x21 are queued in order. While such a write is at the head of the queue, `apply_valid` stays low until `pipe_idle` is high, and the entries behind it wait as well.
- R3: When the queue holds FIFO_DEPTH (default 8) entries, `wr_ready` is low for queued, drain-stall and float-alias addresses, and no write is lost.
- R4: Writes to the direct registers 0x30 and 0x31 are always accepted, even while the queue is full or stalled. They appear on `dir_valid`/`dir_addr`/`dir_data` in the cycle after the accepting edge.
- R5: A write to address base+128 (0x88, 0x89, 0x8C, 0x90) is converted and applied as data of the base register, at the base address. Registers 0x08, 0x09 and 0x10 use a signed 24-bit format with 12 fractional bits. Register 0x0C uses a signed 16-bit format with 4 fractional bits. The result is sign-extended to 32 bits.
- R6: The conversion drops fractional bits by truncating toward zero. A float with a zero exponent field (zero or denormal) converts to 0.
- R7: A converted value outside the format's range saturates to the largest positive or the most negative value of that format. Infinity and NaN saturate according to their sign bit.
- R8: `apply_start` is high exactly when the applied entry has address 0x10. This covers writes made to 0x10 and writes made to 0x90.
- R9: A write to any other address, including base+128 of a register that has no float twin, is accepted with `wr_ready` high and produces no output.
- R10: While `apply_valid` is high and `pipe_accept` is low, `apply_addr` and `apply_data` stay unchanged.
- R11: During reset `apply_valid` and `dir_valid` are low and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write request |
| wr_addr | input | ADDR_W (8) | Register address of the write |
| wr_data | input | DATA_W (32) | Write data (IEEE single for float twins) |
| wr_ready | output | 1 | Write accepted at this edge when high with wr_valid |
| pipe_accept | input | 1 | Pipeline takes the presented entry this cycle |
| pipe_idle | input | 1 | Pipeline holds no in-flight work |
| apply_valid | output | 1 | Queued entry presented to the pipeline |
| apply_addr | output | ADDR_W (8) | Base address of the presented entry |
| apply_data | output | DATA_W (32) | Fixed-point data of the presented entry |
| apply_start | output | 1 | Presented entry launches a primitive |
| dir_valid | output | 1 | Direct register update strobe |
| dir_addr | output | ADDR_W (8) | Direct register address |
| dir_data | output | DATA_W (32) | Direct register data |

## Verification
There are two latencies. A direct write shows on the direct port one cycle after its accepting edge. A queued write can reach the apply port no earlier than the cycle after its edge, and it may appear later depending on the entries ahead of it and on `pipe_idle`. The bench drives inputs after the falling edge and samples shortly afterwards. It keeps its own ordered model of the queue, computes `wr_ready` from the model's fill level, and predicts `apply_valid` in every sampled cycle from the model's head and the `pipe_idle` value it drives. It also checks the direct strobe one sample after each accepted direct write. Converted values come from a bench function that uses real arithmetic, with clamping and truncation toward zero.

// File: rtl/regsched_pkg.sv
`timescale 1ns/1ps
package regsched_pkg;

   typedef enum logic [1:0] {
      CAT_NONE   = 2'd0,
      CAT_QUEUE  = 2'd1,
      CAT_DRAIN  = 2'd2,
      CAT_DIRECT = 2'd3
   } wcat_e;

   localparam int NUM_FMT   = 2;
   localparam int FMT_COLOR = 0;
   localparam int FMT_COORD = 1;

   typedef struct packed {
      wcat_e      cat;
      logic [0:0] fmt;
      logic       floatable;
   } regmap_t;

   localparam logic [6:0] IDX_RED  = 7'h08;
   localparam logic [6:0] IDX_GRN  = 7'h09;
   localparam logic [6:0] IDX_XPOS = 7'h0C;
   localparam logic [6:0] IDX_CMD  = 7'h10;
   localparam logic [6:0] IDX_MODE = 7'h20;
   localparam logic [6:0] IDX_TEX  = 7'h21;
   localparam logic [6:0] IDX_CTRL = 7'h30;
   localparam logic [6:0] IDX_SWAP = 7'h31;

   function automatic int fmt_width(int f);
      return (f == FMT_COORD) ? 16 : 24;
   endfunction

   function automatic int fmt_frac(int f);
      return (f == FMT_COORD) ? 4 : 12;
   endfunction

   function automatic regmap_t reg_lookup(logic [6:0] idx);
      regmap_t m;
      m = '{cat: CAT_NONE, fmt: 1'b0, floatable: 1'b0};
      case (idx)
         IDX_RED, IDX_GRN, IDX_CMD: m = '{cat: CAT_QUEUE, fmt: 1'(FMT_COLOR), floatable: 1'b1};
         IDX_XPOS:                  m = '{cat: CAT_QUEUE, fmt: 1'(FMT_COORD), floatable: 1'b1};
         IDX_MODE, IDX_TEX:         m = '{cat: CAT_DRAIN, fmt: 1'b0, floatable: 1'b0};
         IDX_CTRL, IDX_SWAP:        m = '{cat: CAT_DIRECT, fmt: 1'b0, floatable: 1'b0};
         default:                   m = '{cat: CAT_NONE, fmt: 1'b0, floatable: 1'b0};
      endcase
      return m;
   endfunction

endpackage

// File: rtl/regsched_decode.sv
`timescale 1ns/1ps
module regsched_decode
   import regsched_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr_i,
   output wcat_e             cat_o,
   output logic [0:0]        fmt_o,
   output logic              alias_o,
   output logic [ADDR_W-1:0] base_o
);

   if (ADDR_W < 8) begin : g_bad_addr
      $error("regsched_decode: ADDR_W must be at least 8");
   end

   logic    hi_ok;
   regmap_t map;

   if (ADDR_W > 8) begin : g_wide
      assign hi_ok = ~|addr_i[ADDR_W-1:8];
   end else begin : g_narrow
      assign hi_ok = 1'b1;
   end

   always_comb begin
      map     = reg_lookup(addr_i[6:0]);
      alias_o = addr_i[7];
      fmt_o   = map.fmt;
      base_o  = {{(ADDR_W-7){1'b0}}, addr_i[6:0]};
      if (!hi_ok || (alias_o && !map.floatable)) cat_o = CAT_NONE;
      else                                        cat_o = map.cat;
   end

endmodule

// File: rtl/regsched_f2x.sv
`timescale 1ns/1ps
module regsched_f2x #(
   parameter int DATA_W = 32,
   parameter int FIX_W  = 24,
   parameter int FIX_F  = 12
) (
   input  logic [31:0]       flt_i,
   output logic [DATA_W-1:0] fix_o
);

   if (FIX_W < 2 || FIX_W > DATA_W || FIX_F >= FIX_W) begin : g_bad_fmt
      $error("regsched_f2x: format does not fit the data word");
   end

   localparam logic signed [10:0] FRAC_S  = 11'(FIX_F);
   localparam logic signed [10:0] WIDTH_S = 11'(FIX_W);
   localparam logic [63:0] LIM_NEG = 64'd1 << (FIX_W - 1);
   localparam logic [63:0] LIM_POS = LIM_NEG - 64'd1;

   logic              sgn;
   logic [7:0]        ex;
   logic [23:0]       man;
   logic signed [10:0] sh;
   logic [10:0]       nsh;
   logic [63:0]       mag;
   logic              sat;

   always_comb begin
      sgn = flt_i[31];
      ex  = flt_i[30:23];
      man = {1'b1, flt_i[22:0]};
      sh  = $signed({3'b000, ex}) - 11'sd150 + FRAC_S;
      nsh = 11'(-sh);
      mag = '0;
      sat = 1'b0;
      if (ex == 8'h00) begin
         mag = '0;
      end else if (ex == 8'hFF) begin
         sat = 1'b1;
      end else if (!sh[10]) begin
         if (sh > WIDTH_S) sat = 1'b1;
         else              mag = {40'b0, man} << sh[5:0];
      end else if (nsh < 11'd24) begin
         mag = {40'b0, man} >> nsh[4:0];
      end
      if (!sat) sat = sgn ? (mag > LIM_NEG) : (mag > LIM_POS);
      if (sat)      fix_o = sgn ? DATA_W'(~LIM_NEG + 64'd1) : DATA_W'(LIM_POS);
      else if (sgn) fix_o = DATA_W'(~mag + 64'd1);
      else          fix_o = DATA_W'(mag);
   end

endmodule

// File: rtl/regsched_fifo.sv
`timescale 1ns/1ps
module regsched_fifo #(
   parameter int WIDTH = 41,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [WIDTH-1:0] din_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] head_o,
   output logic             empty_o,
   output logic             full_o
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("regsched_fifo: DEPTH must be a power of two of at least 2");
   end

   localparam int PW = $clog2(DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr;
   logic [PW:0]      cnt;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push_i && wr_ptr == PW'(g)) mem[g] <= din_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push_i) wr_ptr <= wr_ptr + 1'b1;
         if (pop_i)  rd_ptr <= rd_ptr + 1'b1;
         cnt <= cnt + (PW+1)'(push_i) - (PW+1)'(pop_i);
      end
   end

   assign head_o  = mem[rd_ptr];
   assign empty_o = (cnt == '0);
   assign full_o  = (cnt == (PW+1)'(DEPTH));

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);

   a_r1_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);

   a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= (PW+1)'(DEPTH));

endmodule

// File: rtl/regsched_top.sv
`timescale 1ns/1ps
module regsched_top
   import regsched_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   input  logic              pipe_accept,
   input  logic              pipe_idle,
   output logic              apply_valid,
   output logic [ADDR_W-1:0] apply_addr,
   output logic [DATA_W-1:0] apply_data,
   output logic              apply_start,
   output logic              dir_valid,
   output logic [ADDR_W-1:0] dir_addr,
   output logic [DATA_W-1:0] dir_data
);

   if (DATA_W != 32) begin : g_bad_data
      $error("regsched_top: DATA_W must be 32 to carry single-precision floats");
   end

   localparam int ENTRY_W = 1 + ADDR_W + DATA_W;

   wcat_e             dec_cat;
   logic [0:0]        dec_fmt;
   logic              dec_alias;
   logic [ADDR_W-1:0] dec_base;

   regsched_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr_i  (wr_addr),
      .cat_o   (dec_cat),
      .fmt_o   (dec_fmt),
      .alias_o (dec_alias),
      .base_o  (dec_base)
   );

   logic [DATA_W-1:0] conv_by_fmt [NUM_FMT];

   for (genvar g = 0; g < NUM_FMT; g++) begin : g_conv
      regsched_f2x #(
         .DATA_W (DATA_W),
         .FIX_W  (fmt_width(g)),
         .FIX_F  (fmt_frac(g))
      ) u_f2x (
         .flt_i (wr_data),
         .fix_o (conv_by_fmt[g])
      );
   end

   logic              queued_cat;
   logic              push, pop;
   logic              fifo_empty, fifo_full;
   logic [DATA_W-1:0] wdata_fix;
   logic [ENTRY_W-1:0] head;
   logic              head_drain;

   assign queued_cat = (dec_cat == CAT_QUEUE) || (dec_cat == CAT_DRAIN);
   assign wdata_fix  = dec_alias ? conv_by_fmt[dec_fmt] : wr_data;
   assign wr_ready   = !queued_cat || !fifo_full;
   assign push       = wr_valid && queued_cat && !fifo_full;

   regsched_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push),
      .din_i   ({dec_cat == CAT_DRAIN, dec_base, wdata_fix}),
      .pop_i   (pop),
      .head_o  (head),
      .empty_o (fifo_empty),
      .full_o  (fifo_full)
   );

   assign head_drain  = head[ENTRY_W-1];
   assign apply_addr  = head[DATA_W +: ADDR_W];
   assign apply_data  = head[DATA_W-1:0];
   assign apply_valid = !fifo_empty && (!head_drain || pipe_idle);
   assign pop         = apply_valid && pipe_accept;
   assign apply_start = apply_valid && (apply_addr == ADDR_W'(IDX_CMD));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_valid <= 1'b0;
         dir_addr  <= '0;
         dir_data  <= '0;
      end else begin
         dir_valid <= wr_valid && (dec_cat == CAT_DIRECT);
         if (wr_valid && dec_cat == CAT_DIRECT) begin
            dir_addr <= dec_base;
            dir_data <= wr_data;
         end
      end
   end

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (apply_valid && !pipe_accept) |=> ($stable(apply_addr) && $stable(apply_data)));

   a_r4_direct_next: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && dec_cat == CAT_DIRECT) |=> (dir_valid && dir_data == $past(wr_data)));

   a_r3_backpressure_only_queued: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ready |-> (dec_cat == CAT_QUEUE || dec_cat == CAT_DRAIN));

   a_r9_unmapped_accepted: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && dec_cat == CAT_NONE) |-> (wr_ready && !push));

   a_r2_drain_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (apply_valid && !pipe_idle) |-> !head_drain);

endmodule

// File: tb/regsched_top_tb.sv
`timescale 1ns/1ps
module regsched_top_tb;

   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        wr_ready;
   logic        pipe_accept = 1'b0;
   logic        pipe_idle = 1'b0;
   logic        apply_valid, apply_start, dir_valid;
   logic [7:0]  apply_addr, dir_addr;
   logic [31:0] apply_data, dir_data;

   always #10 clk = ~clk;

   regsched_top #(.ADDR_W(8), .DATA_W(32), .FIFO_DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_ready(wr_ready), .pipe_accept(pipe_accept),
      .pipe_idle(pipe_idle), .apply_valid(apply_valid), .apply_addr(apply_addr),
      .apply_data(apply_data), .apply_start(apply_start), .dir_valid(dir_valid),
      .dir_addr(dir_addr), .dir_data(dir_data)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   logic [7:0]  q_a [$];
   logic [31:0] q_d [$];
   bit          q_dr [$];
   string       q_tag [$];

   bit          exp_dv = 0;
   logic [7:0]  exp_da = '0;
   logic [31:0] exp_dd = '0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // 0 unmapped, 1 queued, 2 drain-stall, 3 direct
   function automatic int bench_cat(input logic [7:0] a);
      case (a)
         8'h08, 8'h09, 8'h0C, 8'h10, 8'h88, 8'h89, 8'h8C, 8'h90: return 1;
         8'h20, 8'h21: return 2;
         8'h30, 8'h31: return 3;
         default: return 0;
      endcase
   endfunction

   function automatic logic [31:0] f2x_model(input logic [31:0] f, input int w,
                                             input int fr, output string tag);
      real r, lim;
      int  v;
      int  e;
      e = int'(f[30:23]);
      tag = "R5";
      if (e == 0) begin
         tag = "R6";
         return 32'd0;
      end
      lim = 2.0 ** (w - 1);
      if (e == 255) begin
         tag = "R7";
         return f[31] ? 32'(-$rtoi(lim)) : 32'($rtoi(lim) - 1);
      end
      r = real'({1'b1, f[22:0]}) * (2.0 ** (e - 150 + fr));
      if (r >= lim) begin
         tag = "R7";
         return f[31] ? 32'(-$rtoi(lim)) : 32'($rtoi(lim) - 1);
      end
      v = $rtoi(r);
      if (real'(v) != r) tag = "R6";
      return f[31] ? 32'(-v) : 32'(v);
   endfunction

   task automatic step(input bit v, input logic [7:0] a, input logic [31:0] d,
                       input bit acc, input bit idle, output bit took);
      int  cat;
      bit  exp_rdy, exp_av;
      string t;
      logic [31:0] xd;
      @(negedge clk);
      wr_valid = v; wr_addr = a; wr_data = d; pipe_accept = acc; pipe_idle = idle;
      #1;
      // R4: direct strobe one cycle after acceptance
      chk(dir_valid == exp_dv, "R4", "dir_valid", 64'(dir_valid), 64'(exp_dv));
      if (exp_dv && dir_valid) begin
         chk(dir_addr == exp_da, "R4", "dir_addr", 64'(dir_addr), 64'(exp_da));
         chk(dir_data == exp_dd, "R4", "dir_data", 64'(dir_data), 64'(exp_dd));
      end
      cat = bench_cat(a);
      exp_rdy = (cat == 0 || cat == 3) || (q_a.size() < DEPTH);
      exp_av = (q_a.size() > 0) && (!q_dr[0] || idle);
      chk(apply_valid == exp_av,
          (q_a.size() > 0 && q_dr[0] && !idle) ? "R2" : "R1",
          "apply_valid", 64'(apply_valid), 64'(exp_av));
      if (exp_av && apply_valid) begin
         chk(apply_addr == q_a[0], q_tag[0], "apply_addr", 64'(apply_addr), 64'(q_a[0]));
         chk(apply_data == q_d[0], q_tag[0], "apply_data", 64'(apply_data), 64'(q_d[0]));
         chk(apply_start == (q_a[0] == 8'h10), "R8", "apply_start",
             64'(apply_start), 64'(q_a[0] == 8'h10));
         if (acc) begin
            void'(q_a.pop_front()); void'(q_d.pop_front());
            void'(q_dr.pop_front()); void'(q_tag.pop_front());
         end
      end
      if (v) chk(wr_ready == exp_rdy, (cat == 0) ? "R9" : (cat == 3) ? "R4" : "R3",
                 "wr_ready", 64'(wr_ready), 64'(exp_rdy));
      took = v && wr_ready;
      exp_dv = 0;
      if (took && cat == 3) begin
         exp_dv = 1; exp_da = a; exp_dd = d;
      end else if (took && cat != 0) begin
         t = (cat == 2) ? "R2" : (a[6:0] == 7'h10) ? "R8" : "R1";
         xd = d;
         if (a[7]) begin
            xd = f2x_model(d, (a[6:0] == 7'h0C) ? 16 : 24, (a[6:0] == 7'h0C) ? 4 : 12, t);
            if (a[6:0] == 7'h10) t = "R8";
         end
         q_a.push_back({1'b0, a[6:0]}); q_d.push_back(xd);
         q_dr.push_back(cat == 2); q_tag.push_back(t);
      end
   endtask

   task automatic send(input logic [7:0] a, input logic [31:0] d, input bit acc, input bit idle);
      bit took;
      step(1'b1, a, d, acc, idle, took);
   endtask

   task automatic flush();
      bit took;
      for (int i = 0; i < 40 && q_a.size() > 0; i++) step(1'b0, 8'h00, 32'd0, 1'b1, 1'b1, took);
      step(1'b0, 8'h00, 32'd0, 1'b1, 1'b1, took);
   endtask

   logic [7:0] addr_pool [16] = '{8'h08, 8'h09, 8'h0C, 8'h10, 8'h20, 8'h21, 8'h30, 8'h31,
                                  8'h88, 8'h89, 8'h8C, 8'h90, 8'hA0, 8'hB0, 8'h05, 8'hFF};

   initial begin
      bit took;
      int seed_dummy;
      logic [7:0]  a;
      logic [31:0] d;
      seed_dummy = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      #1;
      // R11: reset state
      chk(apply_valid == 1'b0, "R11", "apply_valid in reset", 64'(apply_valid), 64'd0);
      chk(dir_valid == 1'b0, "R11", "dir_valid in reset", 64'(dir_valid), 64'd0);
      chk(wr_ready == 1'b1, "R11", "wr_ready in reset", 64'(wr_ready), 64'd1);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 order and R5 conversion
      send(8'h08, 32'h0001_2345, 1, 1);
      send(8'h09, 32'h0000_0777, 1, 1);
      send(8'h88, 32'h3FC0_0000, 1, 1);   // 1.5
      send(8'h89, 32'hC030_0000, 1, 1);   // -2.75
      send(8'h8C, 32'h4148_0000, 1, 1);   // 12.5 in coord format
      // R6 truncation and zero/denormal
      send(8'h88, 32'h3727_C5AC, 1, 1);
      send(8'h89, 32'hBFFF_FFFF, 1, 1);
      send(8'h88, 32'h0000_0001, 1, 1);
      send(8'h88, 32'h8000_0000, 1, 1);
      // R7 saturation
      send(8'h88, 32'h4E6E_6B28, 1, 1);   // 1e9
      send(8'h89, 32'hCE6E_6B28, 1, 1);   // -1e9
      send(8'h8C, 32'h459C_4000, 1, 1);   // 5000 in coord format
      send(8'h88, 32'hFF80_0000, 1, 1);   // -inf
      // R8 start commands
      send(8'h10, 32'h0000_0000, 1, 1);
      send(8'h90, 32'h3F80_0000, 1, 1);
      flush();

      // R2 drain stall blocks head and later entries
      send(8'h20, 32'h0000_00AA, 1, 0);
      send(8'h08, 32'h0000_1000, 1, 0);
      for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 32'd0, 1'b1, 1'b0, took);
      flush();

      // R3 full queue, R10 hold, R4/R9 still accepted
      for (int i = 0; i < DEPTH + 2; i++) send(8'h09, 32'(i), 0, 1);
      send(8'h30, 32'hDEAD_0001, 0, 1);
      send(8'h05, 32'h1234_5678, 0, 1);
      send(8'hA0, 32'h1234_5678, 0, 1);
      send(8'h31, 32'hBEEF_0002, 0, 0);
      flush();

      // constrained random phase
      for (int i = 0; i < 4000; i++) begin
         a = addr_pool[$urandom_range(0, 15)];
         if (a[7]) begin
            case ($urandom_range(0, 19))
               0: d = {1'($urandom), 8'h00, 23'($urandom)};
               1: d = {1'($urandom), 8'hFF, 23'($urandom)};
               2: d = {1'($urandom), 8'(160 + $urandom_range(0, 40)), 23'($urandom)};
               default: d = {1'($urandom), 8'(110 + $urandom_range(0, 40)), 23'($urandom)};
            endcase
         end else begin
            d = $urandom;
         end
         step($urandom_range(0, 9) < 7, a, d, $urandom_range(0, 9) < 7,
              $urandom_range(0, 1) == 1, took);
      end
      flush();

      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #3000000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule